// File: doc/BRIEF.md
# Receive Character Discard Policy Filter

The filter sits between a receive character decoder and a receive FIFO. It sees one decoded character per valid cycle, with a flag that marks special (control) codes, and issues the FIFO write strobe with the character for each one it keeps. A 2-bit mode input picks one of four discard policies. The four policies are: keep everything; collapse each run of adjacent fill characters to its last member; drop every fill character; or drop fill characters together with serial-address markers and the address character that follows each marker. When the FIFO is bypassed, the block keeps everything whatever the mode says.

Run collapse cannot know that a fill character is the last of its run until the next character shows up. A one-entry holding register therefore delays such a fill. Characters that arrive while the holding register is busy pass through it, so the write order always matches the arrival order. The holding register empties in any cycle without an accepted character, unless it holds a fill that is still waiting under the run-collapse policy.

Top module: `rx_discard_filter`

## Requirements
- R1: After reset is released, `wr_en` stays low until a character has been accepted, and nothing is held from before reset.
- R2: With mode 00 (keep all) and `fifo_en` high, every valid character is written in arrival order. With the holding register empty, it is written in the cycle after it arrives.
- R3: With `fifo_en` low, the block acts as mode 00 for any `mode` value, so fill and address-marker characters are written too.
- R4: With mode 01, only the last fill character of a run of adjacent fills is written. It is written once a non-fill character arrives, and that non-fill character follows it.
- R5: With mode 01, a held fill character is not written during cycles with no accepted character while the mode stays 01.
- R6: With mode 10, every fill character (special flag set, code `FILL_CODE`, default 8'h05) is dropped. Data characters, including a data value equal to `FILL_CODE`, and every other special code are written.
- R7: With mode 11, fill characters are dropped. Each serial-address marker (special flag set, code `ADDR_CODE`, default 8'h0A) is dropped, and so is the one valid character after it, whatever its type.
- R8: A fill held under mode 01 is written, in its place in the order, in the first cycle without an accepted character whose effective mode is not 01. A character dropped by policy counts as such a cycle.
- R9: For any mix of characters, gaps, mode changes and `fifo_en` changes, the written sequence equals the sequence the rules of R2 to R8 give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded character is present this cycle |
| in_char | input | CW | Decoded character code |
| in_special | input | 1 | Character is a special (control) code |
| mode | input | 2 | Discard policy: 00 keep all, 01 last fill of run, 10 drop fill, 11 drop fill and addresses |
| fifo_en | input | 1 | Receive FIFO in use; low forces keep-all |
| wr_en | output | 1 | FIFO write strobe |
| wr_char | output | CW | Character written |
| wr_special | output | 1 | Special flag of the character written |

## Verification
The bench builds the filter with its defaults: 8-bit characters, fill code 8'h05 and address-marker code 8'h0A. It deliberately sends plain data bytes that carry those same values, so the special flag alone has to decide how a character is classified. Mode changes during a held fill and back-to-back characters arriving while the holding register is busy are both reachable with these values, since the random stream switches mode and `fifo_en` on any cycle.

// File: rtl/rxdf_pkg.sv
package rxdf_pkg;

  typedef enum logic [1:0] {
    POL_KEEP_ALL      = 2'b00,
    POL_LAST_FILL     = 2'b01,
    POL_DROP_FILL     = 2'b10,
    POL_DROP_FILL_ADR = 2'b11
  } policy_e;

  typedef enum logic [1:0] {
    CLS_DATA = 2'd0,
    CLS_FILL = 2'd1,
    CLS_ADDR = 2'd2,
    CLS_CTRL = 2'd3
  } class_e;

  // A bypassed FIFO forces the keep-all policy.
  function automatic policy_e eff_policy(input logic [1:0] mode, input logic fifo_en);
    return fifo_en ? policy_e'(mode) : POL_KEEP_ALL;
  endfunction

  // Policy-based removal of one character class.
  function automatic logic drop_by_policy(input policy_e p, input class_e c);
    logic fill_gone;
    fill_gone = (p == POL_DROP_FILL) || (p == POL_DROP_FILL_ADR);
    return ((c == CLS_FILL) && fill_gone) ||
           ((c == CLS_ADDR) && (p == POL_DROP_FILL_ADR));
  endfunction

endpackage

// File: rtl/rxdf_classify.sv
module rxdf_classify
  import rxdf_pkg::*;
#(
  parameter int            CW        = 8,
  parameter logic [CW-1:0] FILL_CODE = CW'(5),
  parameter logic [CW-1:0] ADDR_CODE = CW'(10)
) (
  input  logic          special,
  input  logic [CW-1:0] code,
  output class_e        cls
);

  always_comb begin
    if (!special)                cls = CLS_DATA;
    else if (code == FILL_CODE)  cls = CLS_FILL;
    else if (code == ADDR_CODE)  cls = CLS_ADDR;
    else                         cls = CLS_CTRL;
  end

endmodule

// File: rtl/rxdf_policy.sv
module rxdf_policy
  import rxdf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  class_e  cls,
  input  policy_e pol,
  output logic    acc,
  output logic    skip_q
);

  logic drop;

  always_comb begin
    drop = skip_q || drop_by_policy(pol, cls);
    acc  = in_valid && !drop;
  end

  // The character after a dropped address marker is the address itself.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        skip_q <= 1'b0;
    else if (in_valid) skip_q <= !skip_q && (pol == POL_DROP_FILL_ADR) && (cls == CLS_ADDR);
  end

endmodule

// File: rtl/rxdf_stage.sv
module rxdf_stage #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          run_mode,
  input  logic          cur_fill,
  input  logic [CW-1:0] cur_char,
  input  logic          cur_spc,
  output logic          wr_en,
  output logic [CW-1:0] wr_char,
  output logic          wr_special,
  output logic          stg_vld,
  output logic          stg_coll,
  output logic          coll_ev
);

  typedef struct packed {
    logic          spc;
    logic [CW-1:0] code;
  } entry_t;

  entry_t stg_q, cur_e;
  logic   drain_ev, push_ev, direct_ev, load_ev;

  always_comb begin
    cur_e     = '{spc: cur_spc, code: cur_char};
    coll_ev   = acc && stg_vld && stg_coll && cur_fill && run_mode;
    drain_ev  = !acc && stg_vld && (!stg_coll || !run_mode);
    push_ev   = acc && stg_vld && !coll_ev;
    direct_ev = acc && !stg_vld && !(run_mode && cur_fill);
    load_ev   = acc && (stg_vld || (run_mode && cur_fill));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_vld  <= 1'b0;
      stg_coll <= 1'b0;
      stg_q    <= '0;
    end else if (load_ev) begin
      stg_vld  <= 1'b1;
      stg_coll <= run_mode && cur_fill;
      stg_q    <= cur_e;
    end else if (drain_ev) begin
      stg_vld  <= 1'b0;
      stg_coll <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en      <= 1'b0;
      wr_char    <= '0;
      wr_special <= 1'b0;
    end else begin
      wr_en <= drain_ev || push_ev || direct_ev;
      if (drain_ev || push_ev) begin
        wr_char    <= stg_q.code;
        wr_special <= stg_q.spc;
      end else if (direct_ev) begin
        wr_char    <= cur_e.code;
        wr_special <= cur_e.spc;
      end
    end
  end

endmodule

// File: rtl/rx_discard_filter.sv
module rx_discard_filter
  import rxdf_pkg::*;
#(
  parameter int            CW        = 8,
  parameter logic [CW-1:0] FILL_CODE = CW'(5),
  parameter logic [CW-1:0] ADDR_CODE = CW'(10)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] in_char,
  input  logic          in_special,
  input  logic [1:0]    mode,
  input  logic          fifo_en,
  output logic          wr_en,
  output logic [CW-1:0] wr_char,
  output logic          wr_special
);

  policy_e pol;
  class_e  cls;
  logic    is_fill, is_addr, run_mode;
  logic    acc, skip_q;
  logic    stg_vld, stg_coll, coll_ev;

  assign pol      = eff_policy(mode, fifo_en);
  assign is_fill  = (cls == CLS_FILL);
  assign is_addr  = (cls == CLS_ADDR);
  assign run_mode = (pol == POL_LAST_FILL);

  rxdf_classify #(.CW(CW), .FILL_CODE(FILL_CODE), .ADDR_CODE(ADDR_CODE)) u_cls (
    .special (in_special),
    .code    (in_char),
    .cls     (cls)
  );

  rxdf_policy u_pol (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .cls      (cls),
    .pol      (pol),
    .acc      (acc),
    .skip_q   (skip_q)
  );

  rxdf_stage #(.CW(CW)) u_stg (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .run_mode   (run_mode),
    .cur_fill   (is_fill),
    .cur_char   (in_char),
    .cur_spc    (in_special),
    .wr_en      (wr_en),
    .wr_char    (wr_char),
    .wr_special (wr_special),
    .stg_vld    (stg_vld),
    .stg_coll   (stg_coll),
    .coll_ev    (coll_ev)
  );

endmodule

// File: rtl/rxdf_checker.sv
module rxdf_checker
  import rxdf_pkg::*;
#(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [CW-1:0] in_char,
  input logic          fifo_en,
  input logic          is_fill,
  input logic          is_addr,
  input policy_e       pol,
  input logic          acc,
  input logic          stg_vld,
  input logic          stg_coll,
  input logic          skip_q,
  input logic          coll_ev,
  input logic          wr_en,
  input logic [CW-1:0] wr_char
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !wr_en);

  // R3
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !fifo_en && !stg_vld && !skip_q |=> wr_en && (wr_char == $past(in_char)));

  // R4
  run_collapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coll_ev |=> !wr_en && stg_vld);

  // R5
  held_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stg_vld && stg_coll && !acc && (pol == POL_LAST_FILL) |=> stg_vld && !wr_en);

  // R6
  drop_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_fill && !stg_vld && ((pol == POL_DROP_FILL) || (pol == POL_DROP_FILL_ADR)) |=> !wr_en);

  // R7
  addr_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_addr && !skip_q && (pol == POL_DROP_FILL_ADR) |=> skip_q);

  // R8
  held_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stg_vld && stg_coll && !acc && (pol != POL_LAST_FILL) |=> wr_en && !stg_vld);

endmodule

bind rx_discard_filter rxdf_checker #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_char  (in_char),
  .fifo_en  (fifo_en),
  .is_fill  (is_fill),
  .is_addr  (is_addr),
  .pol      (pol),
  .acc      (acc),
  .stg_vld  (stg_vld),
  .stg_coll (stg_coll),
  .skip_q   (skip_q),
  .coll_ev  (coll_ev),
  .wr_en    (wr_en),
  .wr_char  (wr_char)
);

// File: tb/rx_discard_filter_test.sv
`timescale 1ns/1ps
module rx_discard_filter_test;

  localparam int         CW   = 8;
  localparam logic [7:0] FILL = 8'h05;
  localparam logic [7:0] ADR  = 8'h0A;
  localparam logic [7:0] CTL  = 8'h1C;
  localparam int         QD   = 8192;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [CW-1:0] in_char = '0;
  logic          in_special = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          fifo_en = 1'b1;
  logic          wr_en;
  logic [CW-1:0] wr_char;
  logic          wr_special;

  int tests = 0;
  int fails = 0;

  logic [8:0] exp_q [QD];
  logic [8:0] got_q [QD];
  int n_exp = 0;
  int n_got = 0;

  logic       m_held = 1'b0;
  logic [8:0] m_hval = '0;
  logic       m_skip = 1'b0;

  always #10 clk = ~clk;

  rx_discard_filter #(.CW(CW), .FILL_CODE(FILL), .ADDR_CODE(ADR)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_char(in_char),
    .in_special(in_special), .mode(mode), .fifo_en(fifo_en),
    .wr_en(wr_en), .wr_char(wr_char), .wr_special(wr_special)
  );

  always @(negedge clk) begin
    if (rst_n && wr_en && n_got < QD) begin
      got_q[n_got] = {wr_special, wr_char};
      n_got = n_got + 1;
    end
  end

  function automatic int pol_of(input logic [1:0] m, input logic fe);
    return fe ? int'(m) : 0;
  endfunction

  task automatic push_exp(input logic [8:0] v);
    if (n_exp < QD) begin
      exp_q[n_exp] = v;
      n_exp = n_exp + 1;
    end
  endtask

  // Character-level reference of the policy rules.
  task automatic model(input logic v, input logic [7:0] c, input logic s, input logic [1:0] m, input logic fe);
    int  p;
    logic f, a, drop;
    p = pol_of(m, fe);
    f = s && (c == FILL);
    a = s && (c == ADR);
    drop = 1'b0;
    if (v) begin
      if (m_skip) begin
        drop = 1'b1;
        m_skip = 1'b0;
      end else begin
        drop = (f && p >= 2) || (a && p == 3);
        if (a && p == 3) m_skip = 1'b1;
      end
    end
    if (!v || drop) begin
      if (m_held && p != 1) begin
        push_exp(m_hval);
        m_held = 1'b0;
      end
    end else if (f && p == 1) begin
      m_held = 1'b1;
      m_hval = {s, c};
    end else begin
      if (m_held) begin
        push_exp(m_hval);
        m_held = 1'b0;
      end
      push_exp({s, c});
    end
  endtask

  task automatic cyc(input logic v, input logic [7:0] c, input logic s, input logic [1:0] m, input logic fe);
    @(negedge clk);
    in_valid = v; in_char = c; in_special = s; mode = m; fifo_en = fe;
    model(v, c, s, m, fe);
  endtask

  task automatic check(input string req, input logic ok, input int act, input int expv);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Drain with keep-all idles, then compare the written and expected streams.
  task automatic settle_and_compare(input string req);
    int n;
    for (int i = 0; i < 4; i++) cyc(1'b0, 8'h00, 1'b0, 2'b00, 1'b1);
    @(negedge clk);
    #1;
    check({req, " count"}, n_got == n_exp, n_got, n_exp);
    n = (n_got < n_exp) ? n_got : n_exp;
    for (int i = 0; i < n; i++)
      check({req, " element"}, got_q[i] == exp_q[i], int'(got_q[i]), int'(exp_q[i]));
    n_got = 0;
    n_exp = 0;
  endtask

  initial begin
    #(20 * 200000);
    fails = fails + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int g0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: quiet after reset
    check("R1 wr_en in reset", wr_en == 1'b0, int'(wr_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wr_en after release", wr_en == 1'b0, int'(wr_en), 0);

    // R2: latency of one cycle with empty holding register
    cyc(1'b1, 8'h3C, 1'b0, 2'b00, 1'b1);
    cyc(1'b0, 8'h00, 1'b0, 2'b00, 1'b1);
    check("R2 one-cycle write strobe", wr_en == 1'b1, int'(wr_en), 1);
    check("R2 one-cycle write data", wr_char == 8'h3C, int'(wr_char), 'h3C);
    cyc(1'b1, FILL, 1'b1, 2'b00, 1'b1);
    cyc(1'b1, ADR, 1'b1, 2'b00, 1'b1);
    cyc(1'b1, 8'h77, 1'b0, 2'b00, 1'b1);
    cyc(1'b1, FILL, 1'b1, 2'b00, 1'b1);
    cyc(1'b1, FILL, 1'b1, 2'b00, 1'b1);
    settle_and_compare("R2");

    // R3: bypassed FIFO ignores mode 11
    cyc(1'b1, FILL, 1'b1, 2'b11, 1'b0);
    cyc(1'b1, ADR, 1'b1, 2'b11, 1'b0);
    cyc(1'b1, 8'h42, 1'b0, 2'b11, 1'b0);
    cyc(1'b1, FILL, 1'b1, 2'b10, 1'b0);
    settle_and_compare("R3");

    // R4 and R5: run collapse, held fill waits through idles
    cyc(1'b1, FILL, 1'b1, 2'b01, 1'b1);
    cyc(1'b1, FILL, 1'b1, 2'b01, 1'b1);
    cyc(1'b1, FILL, 1'b1, 2'b01, 1'b1);
    cyc(1'b1, 8'h11, 1'b0, 2'b01, 1'b1);
    cyc(1'b1, FILL, 1'b1, 2'b01, 1'b1);
    cyc(1'b1, FILL, 1'b1, 2'b01, 1'b1);
    cyc(1'b0, 8'h00, 1'b0, 2'b01, 1'b1);
    g0 = n_got;
    for (int i = 0; i < 5; i++) cyc(1'b0, 8'h00, 1'b0, 2'b01, 1'b1);
    #1;
    check("R5 held fill not written while idle", n_got == g0, n_got, g0);
    cyc(1'b1, CTL, 1'b1, 2'b01, 1'b1);
    settle_and_compare("R4");

    // R6: drop fills, keep data equal to fill code and other specials
    cyc(1'b1, FILL, 1'b1, 2'b10, 1'b1);
    cyc(1'b1, FILL, 1'b0, 2'b10, 1'b1);
    cyc(1'b1, ADR, 1'b1, 2'b10, 1'b1);
    cyc(1'b1, 8'h99, 1'b0, 2'b10, 1'b1);
    cyc(1'b1, CTL, 1'b1, 2'b10, 1'b1);
    cyc(1'b1, FILL, 1'b1, 2'b10, 1'b1);
    settle_and_compare("R6");

    // R7: drop marker and its address character
    cyc(1'b1, ADR, 1'b1, 2'b11, 1'b1);
    cyc(1'b1, 8'h55, 1'b0, 2'b11, 1'b1);
    cyc(1'b1, 8'h66, 1'b0, 2'b11, 1'b1);
    cyc(1'b1, FILL, 1'b1, 2'b11, 1'b1);
    cyc(1'b1, ADR, 1'b1, 2'b11, 1'b1);
    cyc(1'b1, FILL, 1'b1, 2'b11, 1'b1);
    cyc(1'b1, ADR, 1'b0, 2'b11, 1'b1);
    settle_and_compare("R7");

    // R8: held fill flushed when the mode leaves 01
    cyc(1'b1, 8'h21, 1'b0, 2'b01, 1'b1);
    cyc(1'b1, FILL, 1'b1, 2'b01, 1'b1);
    cyc(1'b1, FILL, 1'b1, 2'b10, 1'b1);
    cyc(1'b1, 8'h22, 1'b0, 2'b10, 1'b1);
    cyc(1'b1, FILL, 1'b1, 2'b01, 1'b1);
    cyc(1'b0, 8'h00, 1'b0, 2'b11, 1'b1);
    settle_and_compare("R8");

    // R9: constrained random stream
    for (int blk = 0; blk < 6; blk++) begin
      logic [1:0] m;
      logic fe;
      m = 2'($urandom % 4);
      fe = 1'b1;
      for (int i = 0; i < 500; i++) begin
        int r;
        logic [7:0] c;
        logic s;
        if ($urandom % 8 == 0) m = 2'($urandom % 4);
        if ($urandom % 16 == 0) fe = ~fe;
        r = int'($urandom % 8);
        case (r)
          0, 1, 2: begin c = FILL; s = 1'b1; end
          3:       begin c = ADR;  s = 1'b1; end
          4:       begin c = CTL;  s = 1'b1; end
          default: begin c = 8'($urandom); s = 1'b0; end
        endcase
        cyc(($urandom % 4) != 0, c, s, m, fe);
      end
      settle_and_compare("R9");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule